// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This block holds an interrupt enable register and an interrupt status register for each locality of a multi-locality host interface. All localities share one interrupt request line. Four event sources can raise it: data available, status valid, locality changed and command ready. Event logic elsewhere in the chip reports each event as a single-cycle pulse. The pulse carries the target locality and a four-bit source vector. A status bit is latched, and the line raised, only when the locality's global enable and that source's own enable are both set.

The host reaches the registers with word-addressed reads and writes. Byte lanes are selected by a byte-enable vector, and every access is tagged with the locality that issued it. Reads are allowed from any locality. Enable and status writes take effect only when they come from the locality that currently holds the interface. Status bits are cleared by writing ones. The line is a level that stays high until a clearing write leaves the written locality's status word at zero. The vector register returns a fixed value.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset, every locality's enable register reads 0x00000008 (polarity field bits [4:3] = 01, all enables clear), every status register reads 0, and `irq` is low.
- R2: The enable register is at word 2 (byte offset 0x08), the vector register at word 3 (0x0C) and the status register at word 4 (0x10). The vector register reads the parameter `VEC_VALUE` (default 0). Other words read 0. `rdata` is loaded at the clock edge that samples `rd_en` and otherwise holds its value.
- R3: Status bits map from `evt_src` as follows: `evt_src[0]` sets data-available (status bit 0), `evt_src[1]` sets status-valid (bit 1), `evt_src[2]` sets locality-changed (bit 2) and `evt_src[3]` sets command-ready (bit 7). An event sets a bit when enable bit 31 and the same bit position in the enable register are both 1. `irq` rises at the same edge.
- R4: An event on a source whose enable bit is 0, or with enable bit 31 clear, latches no status bit and leaves `irq` unchanged.
- R5: An event whose `evt_loc` is not below `NUM_LOC` changes no register and does not raise `irq`.
- R6: An enable write stores only bits 31, 7, 4, 3, 2, 1 and 0. All other bits read back as 0.
- R7: An enable or status write is ignored when `act_valid` is low or when `acc_loc` differs from `act_loc`.
- R8: A status write clears each status bit among 0, 1, 2 and 7 that is written as 1. Ones written to other positions have no effect.
- R9: `irq` falls only at a status write that clears at least one pending bit and leaves that locality's status at zero. A partial clear keeps `irq` high. So does a write that clears nothing, such as a write from a locality with no pending bits.
- R10: `byte_en[k]` selects bits [8k+7:8k]. In enable and status writes, unselected lanes keep their contents.
- R11: Writes to the vector register change no register.
- R12: When an event and a clearing status write hit the same locality and bit in the same cycle, the event wins: the bit stays set and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | A locality currently holds the interface |
| act_loc | input | LOC_W | Locality holding the interface |
| evt_valid | input | 1 | Event pulse |
| evt_loc | input | LOC_W | Locality the event belongs to |
| evt_src | input | 4 | Event sources: [0] data avail, [1] status valid, [2] locality changed, [3] command ready |
| acc_loc | input | LOC_W | Locality issuing the host access |
| reg_word | input | WORD_W | Register word offset (byte offset / 4) |
| byte_en | input | 4 | Byte lanes of the write |
| wr_en | input | 1 | Host write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Host read strobe |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Shared interrupt request, active high level |

## Verification
Register contents and `irq` change at the same rising edge that samples a write strobe or an event pulse. `rdata` holds the value addressed at the edge that sampled `rd_en`. The bench therefore drives each stimulus on a falling edge, removes it on the next falling edge, and samples results only then: exactly one rising edge after the stimulus. Same-cycle collisions are driven in that one cycle and checked the same way.

// File: rtl/loc_irq_pkg.sv
// Shared constants and helpers for the per-locality interrupt unit.
// Assumes a 32-bit register width and the fixed bit layout below.
package loc_irq_pkg;

    localparam int DW = 32;

    // bit positions inside enable/status words
    localparam int B_DAV = 0;
    localparam int B_STV = 1;
    localparam int B_LCH = 2;
    localparam int B_CRD = 7;
    localparam int B_GEN = 31;

    localparam logic [DW-1:0] SRC_MASK = 32'h0000_0087;
    localparam logic [DW-1:0] POL_MASK = 32'h0000_0018;
    localparam logic [DW-1:0] EN_WMASK = SRC_MASK | POL_MASK | (32'h1 << B_GEN);
    localparam logic [DW-1:0] EN_RESET = 32'h0000_0008;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_EN,
        SEL_VEC,
        SEL_ST
    } reg_sel_e;

    // map the 4-bit event source vector onto status bit positions
    function automatic logic [DW-1:0] src_to_bits(input logic [3:0] src);
        logic [DW-1:0] b;
        b        = '0;
        b[B_DAV] = src[0];
        b[B_STV] = src[1];
        b[B_LCH] = src[2];
        b[B_CRD] = src[3];
        return b;
    endfunction

endpackage

// File: rtl/loc_irq_decode.sv
// Host access decoder: picks the addressed register, builds the byte-lane
// bit mask and the per-locality write strobes. Write strobes are gated by
// ownership (the access locality must be the active one).
// Assumes word addressing; purely combinational.
module loc_irq_decode
    import loc_irq_pkg::*;
#(
    parameter int NUM_LOC  = 5,
    parameter int LOC_W    = 3,
    parameter int WORD_W   = 10,
    parameter int EN_WORD  = 2,
    parameter int VEC_WORD = 3,
    parameter int ST_WORD  = 4
) (
    input  logic              act_valid,
    input  logic [LOC_W-1:0]  act_loc,
    input  logic [LOC_W-1:0]  acc_loc,
    input  logic [WORD_W-1:0] reg_word,
    input  logic [3:0]        byte_en,
    input  logic              wr_en,
    output reg_sel_e          sel,
    output logic [DW-1:0]     lane_mask,
    output logic [NUM_LOC-1:0] acc_hit,
    output logic [NUM_LOC-1:0] en_wr,
    output logic [NUM_LOC-1:0] st_wr
);

    logic owner;

    // select the addressed register
    always_comb begin
        if (reg_word == WORD_W'(EN_WORD))       sel = SEL_EN;
        else if (reg_word == WORD_W'(VEC_WORD)) sel = SEL_VEC;
        else if (reg_word == WORD_W'(ST_WORD))  sel = SEL_ST;
        else                                    sel = SEL_NONE;
    end

    // the issuing locality owns the interface
    assign owner = act_valid && (acc_loc == act_loc);

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_lane
            assign lane_mask[8*k +: 8] = {8{byte_en[k]}};
        end
        for (k = 0; k < NUM_LOC; k++) begin : g_loc
            assign acc_hit[k] = (acc_loc == LOC_W'(k));
            assign en_wr[k]   = wr_en && owner && acc_hit[k] && (sel == SEL_EN);
            assign st_wr[k]   = wr_en && owner && acc_hit[k] && (sel == SEL_ST);
        end
    endgenerate

endmodule

// File: rtl/loc_irq_bank.sv
// One locality's enable and status registers. Latches enabled events,
// applies byte-laned enable writes and write-one-to-clear status writes,
// and reports whether it latched an event or was cleared to zero.
// Assumes strobes are already ownership-qualified by the decoder.
module loc_irq_bank
    import loc_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_hit,
    input  logic [DW-1:0] evt_bits,
    input  logic          en_wr,
    input  logic          st_wr,
    input  logic [DW-1:0] lane_mask,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] st_q,
    output logic          latched,
    output logic          zeroed
);

    logic [DW-1:0] set_bits;
    logic [DW-1:0] clr_bits;
    logic [DW-1:0] st_d;
    logic [DW-1:0] en_d;

    // events pass only with global and per-source enable
    assign set_bits = (evt_hit && en_q[B_GEN]) ? (evt_bits & en_q & SRC_MASK) : '0;
    // ones written to supported bits in addressed lanes clear
    assign clr_bits = st_wr ? (wdata & lane_mask & SRC_MASK) : '0;
    // set has priority over clear
    assign st_d     = (st_q & ~clr_bits) | set_bits;
    // enable write keeps unaddressed lanes, stores only writable bits
    assign en_d     = en_wr ? ((en_q & ~lane_mask) | (wdata & lane_mask & EN_WMASK)) : en_q;

    assign latched  = |set_bits;
    assign zeroed   = st_wr && (|(st_q & clr_bits)) && (st_d == '0);

    // register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= EN_RESET;
            st_q <= '0;
        end else begin
            en_q <= en_d;
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/loc_irq_line.sv
// Shared interrupt line: set by any latch, dropped by a clear-to-zero.
// Assumes set wins over clear in the same cycle.
module loc_irq_line #(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] latched,
    input  logic [NUM_LOC-1:0] zeroed,
    output logic               irq
);

    // level register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)          irq <= 1'b0;
        else if (|latched)   irq <= 1'b1;
        else if (|zeroed)    irq <= 1'b0;
    end

endmodule

// File: rtl/loc_irq_unit.sv
// Top of the per-locality interrupt enable/status unit. Instantiates the
// decoder, one register bank per locality and the shared line, and
// registers read data. Assumes single-cycle event pulses and strobes.
module loc_irq_unit
    import loc_irq_pkg::*;
#(
    parameter int          NUM_LOC   = 5,
    parameter int          LOC_W     = 3,
    parameter int          WORD_W    = 10,
    parameter logic [31:0] VEC_VALUE = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_valid,
    input  logic [LOC_W-1:0]  act_loc,
    input  logic              evt_valid,
    input  logic [LOC_W-1:0]  evt_loc,
    input  logic [3:0]        evt_src,
    input  logic [LOC_W-1:0]  acc_loc,
    input  logic [WORD_W-1:0] reg_word,
    input  logic [3:0]        byte_en,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic              irq
);

    localparam int FLAT_W = NUM_LOC * DW;

    reg_sel_e           sel;
    logic [DW-1:0]      lane_mask;
    logic [NUM_LOC-1:0] acc_hit;
    logic [NUM_LOC-1:0] en_wr;
    logic [NUM_LOC-1:0] st_wr;
    logic [NUM_LOC-1:0] latched;
    logic [NUM_LOC-1:0] zeroed;
    logic [DW-1:0]      evt_bits;
    logic [FLAT_W-1:0]  en_flat;
    logic [FLAT_W-1:0]  st_flat;
    logic [DW-1:0]      rd_word;

    assign evt_bits = src_to_bits(evt_src);

    loc_irq_decode #(
        .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .WORD_W(WORD_W)
    ) u_dec (
        .act_valid(act_valid), .act_loc(act_loc), .acc_loc(acc_loc),
        .reg_word(reg_word), .byte_en(byte_en), .wr_en(wr_en),
        .sel(sel), .lane_mask(lane_mask), .acc_hit(acc_hit),
        .en_wr(en_wr), .st_wr(st_wr)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_LOC; i++) begin : g_bank
            logic [DW-1:0] en_i;
            logic [DW-1:0] st_i;
            loc_irq_bank u_bank (
                .clk(clk), .rst_n(rst_n),
                .evt_hit(evt_valid && (evt_loc == LOC_W'(i))),
                .evt_bits(evt_bits),
                .en_wr(en_wr[i]), .st_wr(st_wr[i]),
                .lane_mask(lane_mask), .wdata(wdata),
                .en_q(en_i), .st_q(st_i),
                .latched(latched[i]), .zeroed(zeroed[i])
            );
            assign en_flat[i*DW +: DW] = en_i;
            assign st_flat[i*DW +: DW] = st_i;
        end
    endgenerate

    loc_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
        .clk(clk), .rst_n(rst_n),
        .latched(latched), .zeroed(zeroed), .irq(irq)
    );

    // read mux over the accessing locality's registers
    always_comb begin
        rd_word = '0;
        for (int j = 0; j < NUM_LOC; j++) begin
            if (acc_hit[j]) begin
                case (sel)
                    SEL_EN:  rd_word = en_flat[j*DW +: DW];
                    SEL_ST:  rd_word = st_flat[j*DW +: DW];
                    SEL_VEC: rd_word = VEC_VALUE;
                    default: rd_word = '0;
                endcase
            end
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

endmodule

// File: rtl/loc_irq_unit_chk.sv
// Property checker for loc_irq_unit, bound into every instance.
module loc_irq_unit_chk #(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 act_valid,
    input logic [LOC_W-1:0]     act_loc,
    input logic                 evt_valid,
    input logic [LOC_W-1:0]     evt_loc,
    input logic [LOC_W-1:0]     acc_loc,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [31:0]          rdata,
    input logic                 irq,
    input logic [NUM_LOC*32-1:0] en_flat,
    input logic [NUM_LOC*32-1:0] st_flat
);

    logic glob_on;
    logic owns;

    // global enable of the locality an event targets
    always_comb begin
        glob_on = 1'b0;
        for (int i = 0; i < NUM_LOC; i++)
            if (evt_loc == LOC_W'(i)) glob_on = en_flat[i*32+31];
    end

    assign owns = act_valid && (acc_loc == act_loc);

    // R3
    irq_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(evt_valid));

    // R9
    irq_fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en));

    // R7
    foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !owns && !evt_valid) |=> ($stable(en_flat) && $stable(st_flat) && $stable(irq)));

    // R4
    global_off_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !wr_en && !glob_on) |=> ($stable(st_flat) && $stable(irq)));

    // R2
    rdata_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind loc_irq_unit loc_irq_unit_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_loc(act_loc),
    .evt_valid(evt_valid), .evt_loc(evt_loc), .acc_loc(acc_loc),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq),
    .en_flat(en_flat), .st_flat(st_flat)
);

// File: tb/loc_irq_unit_test.sv
module loc_irq_unit_test;

    localparam int WW = 10;
    localparam logic [WW-1:0] W_EN  = 10'd2;
    localparam logic [WW-1:0] W_VEC = 10'd3;
    localparam logic [WW-1:0] W_ST  = 10'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_valid = 1'b0;
    logic [2:0]  act_loc = '0;
    logic        evt_valid = 1'b0;
    logic [2:0]  evt_loc = '0;
    logic [3:0]  evt_src = '0;
    logic [2:0]  acc_loc = '0;
    logic [WW-1:0] reg_word = '0;
    logic [3:0]  byte_en = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    loc_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_loc(act_loc),
        .evt_valid(evt_valid), .evt_loc(evt_loc), .evt_src(evt_src),
        .acc_loc(acc_loc), .reg_word(reg_word), .byte_en(byte_en),
        .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] loc, input logic [WW-1:0] w,
                      input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        acc_loc = loc; reg_word = w; wdata = d; byte_en = be; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] loc, input logic [WW-1:0] w,
                      output logic [31:0] v);
        @(negedge clk);
        acc_loc = loc; reg_word = w; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic ev(input logic [2:0] loc, input logic [3:0] src);
        @(negedge clk);
        evt_loc = loc; evt_src = src; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] loc,
                           input logic [WW-1:0] w, input logic [31:0] exp);
        logic [31:0] v;
        rd(loc, w, v);
        check(req, "register read", v, exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 5; i++) begin
            chk_reg("R1", 3'(i), W_EN, 32'h8);
            chk_reg("R1", 3'(i), W_ST, 32'h0);
        end
        check("R1", "irq after reset", {31'b0, irq}, 32'h0);
        chk_reg("R2", 3'd0, W_VEC, 32'h0);
        chk_reg("R2", 3'd0, 10'd5, 32'h0);
    endtask

    task automatic t_enable_mask();
        act_valid = 1'b1; act_loc = 3'd1;
        wr(3'd1, W_EN, 32'hFFFF_FFFF, 4'hF);
        chk_reg("R6", 3'd1, W_EN, 32'h8000_009F);
    endtask

    task automatic t_disabled();
        wr(3'd1, W_EN, 32'h8000_0001, 4'hF);
        ev(3'd1, 4'b0010);
        chk_reg("R4", 3'd1, W_ST, 32'h0);
        check("R4", "irq source off", {31'b0, irq}, 32'h0);
        wr(3'd1, W_EN, 32'h0000_009F, 4'hF);
        ev(3'd1, 4'b0001);
        chk_reg("R4", 3'd1, W_ST, 32'h0);
        check("R4", "irq global off", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_latch();
        wr(3'd1, W_EN, 32'h8000_008F, 4'hF);
        ev(3'd1, 4'b0001);
        check("R3", "irq after event", {31'b0, irq}, 32'h1);
        chk_reg("R3", 3'd1, W_ST, 32'h1);
        ev(3'd1, 4'b1000);
        chk_reg("R3", 3'd1, W_ST, 32'h81);
        ev(3'd1, 4'b0100);
        chk_reg("R3", 3'd1, W_ST, 32'h85);
    endtask

    task automatic t_clear();
        wr(3'd1, W_ST, 32'h1, 4'hF);
        chk_reg("R8", 3'd1, W_ST, 32'h84);
        check("R9", "irq after partial clear", {31'b0, irq}, 32'h1);
        wr(3'd1, W_ST, 32'h84, 4'hF);
        check("R9", "irq after full clear", {31'b0, irq}, 32'h0);
        chk_reg("R8", 3'd1, W_ST, 32'h0);
    endtask

    task automatic t_unsupported();
        ev(3'd1, 4'b0010);
        wr(3'd1, W_ST, 32'h7FFF_FF78, 4'hF);
        chk_reg("R8", 3'd1, W_ST, 32'h2);
        check("R8", "irq after unsupported ones", {31'b0, irq}, 32'h1);
        wr(3'd1, W_ST, 32'h2, 4'hF);
        check("R9", "irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_foreign();
        ev(3'd1, 4'b0001);
        act_loc = 3'd2;
        wr(3'd1, W_ST, 32'hFFFF_FFFF, 4'hF);
        chk_reg("R7", 3'd1, W_ST, 32'h1);
        check("R7", "irq after foreign write", {31'b0, irq}, 32'h1);
        wr(3'd1, W_EN, 32'h0, 4'hF);
        chk_reg("R7", 3'd1, W_EN, 32'h8000_008F);
        act_valid = 1'b0;
        wr(3'd1, W_ST, 32'h1, 4'hF);
        chk_reg("R7", 3'd1, W_ST, 32'h1);
        act_valid = 1'b1;
        wr(3'd2, W_ST, 32'hFF, 4'hF);
        check("R9", "irq after write clearing nothing", {31'b0, irq}, 32'h1);
        act_loc = 3'd1;
        wr(3'd1, W_ST, 32'h1, 4'hF);
        check("R9", "irq after owner clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_invalid();
        ev(3'd5, 4'b0001);
        ev(3'd7, 4'b1111);
        check("R5", "irq after invalid locality", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 5; i++) chk_reg("R5", 3'(i), W_ST, 32'h0);
    endtask

    task automatic t_lanes();
        wr(3'd1, W_EN, 32'h0, 4'b0001);
        chk_reg("R10", 3'd1, W_EN, 32'h8000_0000);
        wr(3'd1, W_EN, 32'h0, 4'b1000);
        chk_reg("R10", 3'd1, W_EN, 32'h0);
        wr(3'd1, W_EN, 32'hFFFF_FFFF, 4'b0001);
        chk_reg("R10", 3'd1, W_EN, 32'h9F);
        wr(3'd1, W_EN, 32'h8000_0000, 4'b1000);
        ev(3'd1, 4'b1001);
        chk_reg("R10", 3'd1, W_ST, 32'h81);
        wr(3'd1, W_ST, 32'hFFFF_FFFF, 4'b0010);
        chk_reg("R10", 3'd1, W_ST, 32'h81);
        wr(3'd1, W_ST, 32'h1, 4'b0001);
        chk_reg("R10", 3'd1, W_ST, 32'h80);
        check("R10", "irq after lane clear", {31'b0, irq}, 32'h1);
        wr(3'd1, W_ST, 32'h80, 4'b0001);
        check("R10", "irq after final lane clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_vector();
        wr(3'd1, W_VEC, 32'hFFFF_FFFF, 4'hF);
        chk_reg("R11", 3'd1, W_VEC, 32'h0);
        chk_reg("R11", 3'd1, W_EN, 32'h8000_009F);
        chk_reg("R11", 3'd1, W_ST, 32'h0);
    endtask

    task automatic t_collide();
        ev(3'd1, 4'b0001);
        @(negedge clk);
        evt_loc = 3'd1; evt_src = 4'b0001; evt_valid = 1'b1;
        acc_loc = 3'd1; reg_word = W_ST; wdata = 32'h1; byte_en = 4'hF; wr_en = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0; wr_en = 1'b0;
        check("R12", "irq after collision", {31'b0, irq}, 32'h1);
        chk_reg("R12", 3'd1, W_ST, 32'h1);
        wr(3'd1, W_ST, 32'h1, 4'hF);
        check("R12", "irq after later clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_mask();
        t_disabled();
        t_latch();
        t_clear();
        t_unsupported();
        t_foreign();
        t_invalid();
        t_lanes();
        t_vector();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule